// File: doc/BRIEF.md
# Auto-Stepping Modulo Address Pointer

This block generates the operand address for a data RAM that delivers one operand to a multiply-accumulate datapath on every cycle. It holds a 9-bit pointer that covers a 512-word space. After each strobed access, the pointer moves by one word, up or down. The caller does not have to compute the next address.

The pointer can also walk a circular buffer of 2 to 256 words. The buffer occupies an aligned window whose size is the smallest power of two that is not less than the length. The window base is the pointer with its low offset bits cleared. An increment past the last word of the buffer returns to the base. A decrement below the base goes to the last word. With modulo mode off, the pointer wraps across the whole 9-bit space.

A load port writes a new pointer value, and that value has priority over stepping in the same cycle. The address output is the registered pointer itself, so each update is visible one clock after the edge that takes it.

Top module: `modulo_ptr_gen`

## Requirements
- R1: While rst_ni is low, addr_o is 0. The pointer stays 0 until the first load or step after reset is released.
- R2: When load_i is high at a rising edge, addr_o equals load_val_i after that edge, whatever step_i, dir_dec_i and mod_en_i are.
- R3: When load_i and step_i are both low at an edge, addr_o keeps its value.
- R4: With mod_en_i low, dir_dec_i low and step_i high (no load), addr_o becomes (addr_o + 1) mod 512, so 511 is followed by 0.
- R5: With mod_en_i low, dir_dec_i high and step_i high (no load), addr_o becomes (addr_o - 1) mod 512, so 0 is followed by 511.
- R6: The buffer length is len_m1_i + 1. An len_m1_i value of 0 is treated as 1, giving a length of 2. The window size P is the smallest power of two that is not less than the length. The base is addr_o with its low log2(P) bits cleared, and the offset is addr_o mod P.
- R7: With mod_en_i high, dir_dec_i low and a step: if the offset is at least length-1, addr_o becomes the base. Otherwise it becomes addr_o + 1.
- R8: With mod_en_i high, dir_dec_i high and a step: if the offset is 0 or greater than length-1, addr_o becomes base + length - 1. Otherwise it becomes addr_o - 1.
- R9: In modulo mode a step never changes addr_o bits [8:8] (the bits above the 256-word page), and strobes on consecutive cycles advance the pointer on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Write load_val_i into the pointer |
| load_val_i | input | 9 | New pointer value |
| step_i | input | 1 | Access strobe; post-steps the pointer |
| dir_dec_i | input | 1 | 0 = increment, 1 = decrement |
| mod_en_i | input | 1 | 1 = circular buffer, 0 = linear 9-bit wrap |
| len_m1_i | input | 8 | Circular buffer length minus one |
| addr_o | output | 9 | Current operand address |

## Verification
Every input sampled at a rising edge shows up in addr_o right after that same edge. There is one register stage and no combinational path from inputs to output, so every result is due exactly one cycle after its stimulus. The bench drives inputs on the falling edge and lets the reference model advance on the rising edge. It compares addr_o on the next falling edge, which is one cycle after the stimulus and before new inputs are applied. Each compare is tagged with the requirement that the applied inputs exercise.

// File: rtl/ptr_gen_pkg.sv
package ptr_gen_pkg;
  localparam int unsigned ADDR_W = 9;
  localparam int unsigned LEN_W  = 8;

  typedef enum logic {
    STEP_UP   = 1'b0,
    STEP_DOWN = 1'b1
  } step_dir_e;
endpackage

// File: rtl/mod_mask_gen.sv
module mod_mask_gen #(
  parameter int unsigned LW = 8
) (
  input  logic [LW-1:0] len_m1_i,
  output logic [LW-1:0] lim_o,
  output logic [LW-1:0] mask_o
);
  logic [LW-1:0] lim;

  // length 1 is not a buffer; promote to 2
  assign lim   = (len_m1_i == '0) ? LW'(1) : len_m1_i;
  assign lim_o = lim;

  // smear: window mask = next pow2 >= length, minus one
  for (genvar i = 0; i < LW; i++) begin : g_smear
    assign mask_o[i] = |lim[LW-1:i];
  end
endmodule

// File: rtl/ptr_step_unit.sv
module ptr_step_unit
  import ptr_gen_pkg::*;
#(
  parameter int unsigned AW = 9,
  parameter int unsigned LW = 8
) (
  input  logic [AW-1:0] ptr_i,
  input  step_dir_e     dir_i,
  input  logic          mod_en_i,
  input  logic [LW-1:0] lim_i,
  input  logic [LW-1:0] mask_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] mask_w, lim_w, off, base, up, dn;

  assign mask_w = AW'(mask_i);
  assign lim_w  = AW'(lim_i);
  assign off    = ptr_i & mask_w;
  assign base   = ptr_i & ~mask_w;
  assign up     = ptr_i + AW'(1);
  assign dn     = ptr_i - AW'(1);

  always_comb begin
    if (!mod_en_i) begin
      nxt_o = (dir_i == STEP_DOWN) ? dn : up;
    end else if (dir_i == STEP_UP) begin
      nxt_o = (off >= lim_w) ? base : up;
    end else begin
      // base is aligned and lim <= mask, so OR is the add
      nxt_o = (off == '0 || off > lim_w) ? (base | lim_w) : dn;
    end
  end
endmodule

// File: rtl/modulo_ptr_gen.sv
module modulo_ptr_gen
  import ptr_gen_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned LW = LEN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          dir_dec_i,
  input  logic          mod_en_i,
  input  logic [LW-1:0] len_m1_i,
  output logic [AW-1:0] addr_o
);
  logic [LW-1:0] lim, mask;
  logic [AW-1:0] ptr_q, ptr_nxt;
  step_dir_e     dir;

  assign dir = step_dir_e'(dir_dec_i);

  mod_mask_gen #(.LW(LW)) u_mask (
    .len_m1_i (len_m1_i),
    .lim_o    (lim),
    .mask_o   (mask)
  );

  ptr_step_unit #(.AW(AW), .LW(LW)) u_step (
    .ptr_i    (ptr_q),
    .dir_i    (dir),
    .mod_en_i (mod_en_i),
    .lim_i    (lim),
    .mask_i   (mask),
    .nxt_o    (ptr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (load_i) ptr_q <= load_val_i;
    else if (step_i) ptr_q <= ptr_nxt;
  end

  assign addr_o = ptr_q;
endmodule

// File: rtl/modulo_ptr_gen_chk.sv
module modulo_ptr_gen_chk #(
  parameter int unsigned AW = 9,
  parameter int unsigned LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          load_i,
  input logic [AW-1:0] load_val_i,
  input logic          step_i,
  input logic          dir_dec_i,
  input logic          mod_en_i,
  input logic [LW-1:0] len_m1_i,
  input logic [AW-1:0] addr_o
);
  a_r1_reset_zero: assert property (@(posedge clk_i) !rst_ni |-> addr_o == '0);

  a_r2_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(load_val_i));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(addr_o));

  a_r4_linear_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !mod_en_i && !dir_dec_i)
      |=> addr_o == AW'($past(addr_o) + AW'(1)));

  a_r5_linear_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && !mod_en_i && dir_dec_i)
      |=> addr_o == AW'($past(addr_o) - AW'(1)));

  a_r9_same_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && mod_en_i) |=> (addr_o >> LW) == ($past(addr_o) >> LW));
endmodule

bind modulo_ptr_gen modulo_ptr_gen_chk #(.AW(AW), .LW(LW)) u_chk (.*);

// File: tb/modulo_ptr_gen_bench.sv
module modulo_ptr_gen_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [8:0] load_val_i = '0;
  logic       step_i = 1'b0;
  logic       dir_dec_i = 1'b0;
  logic       mod_en_i = 1'b0;
  logic [7:0] len_m1_i = '0;
  logic [8:0] addr_o;

  int n_chk = 0;
  int n_bad = 0;
  int model = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk_i = ~clk_i;

  modulo_ptr_gen u_modulo_ptr_gen (.*);

  function automatic int ref_next(int p, bit ld, int lv, bit st, bit dn, bit md, int lm1);
    int len, win, base, off;
    if (ld) return lv;
    if (!st) return p;
    if (!md) return dn ? (p + 511) % 512 : (p + 1) % 512;
    len = (lm1 < 1) ? 2 : lm1 + 1;
    win = 1;
    while (win < len) win = win * 2;
    off  = p % win;
    base = p - off;
    if (!dn) return (off >= len - 1) ? base : p + 1;
    return (off == 0 || off > len - 1) ? base + len - 1 : p - 1;
  endfunction

  function automatic string tag_of(bit ld, bit st, bit dn, bit md);
    if (ld) return "R2";
    if (!st) return "R3";
    if (!md) return dn ? "R5" : "R4";
    return dn ? "R8/R6" : "R7/R6";
  endfunction

  task automatic compare(string tag, int exp);
    n_chk++;
    if (int'(addr_o) != exp) begin
      n_bad++;
      $display("FAIL %s: addr_o=%0d expected %0d", tag, addr_o, exp);
    end
  endtask

  // inputs are already set at a falling edge; step one clock and compare
  task automatic tick();
    string t;
    t = tag_of(load_i, step_i, dir_dec_i, mod_en_i);
    @(posedge clk_i);
    model = ref_next(model, load_i, int'(load_val_i), step_i, dir_dec_i, mod_en_i, int'(len_m1_i));
    @(negedge clk_i);
    compare(t, model);
  endtask

  task automatic do_load(int v);
    load_i = 1'b1; load_val_i = 9'(v); tick(); load_i = 1'b0;
  endtask

  task automatic steps(int n, bit dn, bit md, int lm1);
    step_i = 1'b1; dir_dec_i = dn; mod_en_i = md; len_m1_i = 8'(lm1);
    for (int i = 0; i < n; i++) tick();
    step_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk_i);
    step_i = 1'b1;
    @(negedge clk_i);
    compare("R1", 0);
    rst_ni = 1'b1;
    step_i = 1'b0;
    @(negedge clk_i);
    compare("R1", 0);

    // linear wraps
    do_load(509);
    steps(5, 1'b0, 1'b0, 0);    // R4 511 -> 0
    do_load(2);
    steps(5, 1'b1, 1'b0, 0);    // R5 0 -> 511
    steps(0, 1'b0, 1'b0, 0);
    tick();                     // R3 hold
    tick();

    // modulo length 5 in an 8-word window at 0x40
    do_load(9'h40);
    steps(12, 1'b0, 1'b1, 4);   // R7
    steps(12, 1'b1, 1'b1, 4);   // R8
    // loaded outside the buffer but inside the window
    do_load(9'h46);
    steps(1, 1'b0, 1'b1, 4);    // R7 -> 0x40
    do_load(9'h47);
    steps(1, 1'b1, 1'b1, 4);    // R8 -> 0x44
    // length 2 and the promoted 0 setting (R6)
    do_load(9'h1F3);
    steps(5, 1'b0, 1'b1, 1);
    steps(5, 1'b1, 1'b1, 0);
    // full 256 buffer in the upper page, back-to-back strobes (R9)
    do_load(300);
    steps(260, 1'b0, 1'b1, 255);
    steps(260, 1'b1, 1'b1, 255);
    // length 3 inside a 4-word window, R9 at page edge
    do_load(255);
    steps(6, 1'b0, 1'b1, 2);
    // R2 load beats a step in the same cycle
    step_i = 1'b1; mod_en_i = 1'b1; dir_dec_i = 1'b0;
    do_load(77);
    step_i = 1'b0;
    tick();

    // pseudo-random mix
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      load_i     = (lfsr[3:0] == 4'd0);
      step_i     = lfsr[4] | lfsr[5];
      dir_dec_i  = lfsr[6];
      mod_en_i   = lfsr[7] | lfsr[8];
      len_m1_i   = (lfsr[9]) ? 8'(lfsr[15:8]) : 8'(lfsr[11:9]);
      load_val_i = 9'(lfsr[15:7] ^ lfsr[8:0]);
      tick();
    end
    load_i = 1'b0; step_i = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule